// File: doc/BRIEF.md
# Side-band Signal Serial Shifter

This block carries up to sixteen side-band status signals to a CPU over one serial line. A two-bit selection field chooses which of the inputs take part in the frame. Inputs that are not selected are forced to zero. Each input first passes through a two-flop synchronizer. Whenever the selected and masked value changes, the block captures a 20-bit frame and sends it one bit per clock.

A frame is laid out as follows:
- two start bits of value 0, sent first;
- the sixteen masked data bits, least significant first;
- two stop bits of value 1.

The line rests at 1 between frames. A `busy` flag is high for every bit time of a frame.

If the selected inputs change again while a frame is on the line, no frame is lost and none is duplicated. Exactly one further frame follows after a single idle bit time, and it carries the newest values. Changing the selection field is also a change of the selected value whenever it alters the masked word.

Top module: `sideband_serializer`

## Requirements
- R1: A frame is 20 bit times. Bit times 0 and 1 carry 0, bit times 2 to 17 carry data bits 0 to 15 in that order, and bit times 18 and 19 carry 1.
- R2: While no frame is being sent, and directly after reset, `ser_out` is 1 and `busy` is 0.
- R3: When the line is idle, a change of a selected input makes `busy` go high and the first start bit appear after the third rising clock edge following the change, and not before.
- R4: With `sel_mode` = 00 (the reset setting), only input 0 is sent; data bits 1 to 15 are 0.
- R5: With `sel_mode` = 01, inputs 0 to 7 are sent; data bits 8 to 15 are 0.
- R6: With `sel_mode` = 10 or 11, all sixteen inputs are sent, and the two codes select the same inputs, so switching between them alone sends no frame.
- R7: A change confined to inputs that the current mode does not select sends no frame.
- R8: Any number of changes during a frame produce exactly one further frame, carrying the values present when it starts, and it begins after exactly one idle bit time.
- R9: `busy` stays high for exactly 20 consecutive clock cycles per frame.
- R10: A change of `sel_mode` that alters the masked value of the current inputs sends a frame with the new masked value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_in | input | 16 | Side-band status inputs, asynchronous |
| sel_mode | input | 2 | Input selection: 00 input 0 only, 01 inputs 0-7, 10/11 all inputs |
| ser_out | output | 1 | Serial frame line, idle high |
| busy | output | 1 | High during each bit time of a frame |

## Verification
Some internal faults show up as extra frames or missing frames, and the bench catches these within one frame time. These faults include a pending flag that is stuck or never set, and a change detector that compares against the wrong value. A wrong bit counter shows up as a `busy` pulse of the wrong length, or as a missing idle bit between coalesced frames. A wrong mask or shift order corrupts bit times 2 to 17. The scoreboard compares every received frame, bit for bit, with the frame it predicted from the stimulus. An unexpected frame, or a predicted frame that never arrives, is reported when the frame ends or when the run ends.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings of the side-band serial shifter.
// Assumes the selection field is two bits wide.
package sbs_pkg;
    typedef enum logic [1:0] {
        SEL_SUSPEND = 2'b00,
        SEL_LOW     = 2'b01,
        SEL_ALL     = 2'b10,
        SEL_ALL_ALT = 2'b11
    } sel_mode_e;
endpackage

// File: rtl/sbs_sync.sv
`timescale 1ns/1ps
// sbs_sync: multi-flop synchronizer, one chain per bit.
// Assumes each input bit is independent; no bus coherency is implied.
module sbs_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop samples the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            // Later flops let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sbs_select.sv
`timescale 1ns/1ps
// sbs_select: masks the synchronized inputs according to the selection
// mode and flags any change of the masked word against the last cycle.
// Assumes input 0 is always selected; LOW_GROUP inputs form the low group.
module sbs_select
    import sbs_pkg::*;
#(
    parameter int NUM_SIG   = 16,
    parameter int LOW_GROUP = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] sync_i,
    input  logic [1:0]         mode_i,
    output logic [NUM_SIG-1:0] masked_o,
    output logic               changed_o
);
    sel_mode_e          mode_e;
    logic [NUM_SIG-1:0] mask;
    logic [NUM_SIG-1:0] last_q;

    assign mode_e = sel_mode_e'(mode_i);

    for (genvar i = 0; i < NUM_SIG; i++) begin : g_mask
        // Per-bit enable from the selection mode.
        assign mask[i] = (i == 0)
                       || ((mode_e == SEL_LOW) && (i < LOW_GROUP))
                       || (mode_e == SEL_ALL)
                       || (mode_e == SEL_ALL_ALT);
    end

    assign masked_o  = sync_i & mask;
    assign changed_o = (masked_o != last_q);

    // Remember the masked word for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= masked_o;
    end
endmodule

// File: rtl/sbs_shift.sv
`timescale 1ns/1ps
// sbs_shift: builds start/data/stop frames and shifts them out LSB first.
// Holds one pending request so that changes during a frame yield exactly
// one following frame. Assumes data_i is stable in the cycle it is loaded.
module sbs_shift #(
    parameter int NUM_SIG    = 16,
    parameter int START_BITS = 2,
    parameter int STOP_BITS  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] data_i,
    input  logic               changed_i,
    output logic               ser_o,
    output logic               busy_o
);
    localparam int FRAME_LEN = START_BITS + NUM_SIG + STOP_BITS;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    logic [FRAME_LEN-1:0] frame;
    logic [FRAME_LEN-1:0] shreg_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 pend_q;
    logic                 idle;
    logic                 load;

    assign frame = {{STOP_BITS{1'b1}}, data_i, {START_BITS{1'b0}}};
    assign idle  = (cnt_q == '0);
    assign load  = (changed_i || pend_q) && idle;

    // Keep a request alive until a frame is loaded for it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q || changed_i) && !load;
    end

    // Load a new frame or shift the current one by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
            cnt_q   <= '0;
        end else if (load) begin
            shreg_q <= frame;
            cnt_q   <= CNT_W'(FRAME_LEN);
        end else if (!idle) begin
            shreg_q <= {1'b1, shreg_q[FRAME_LEN-1:1]};
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign busy_o = !idle;
    assign ser_o  = idle ? 1'b1 : shreg_q[0];
endmodule

// File: rtl/sideband_serializer.sv
`timescale 1ns/1ps
// sideband_serializer: top of the side-band serial shifter. Synchronizes
// the inputs, masks them by mode, and sends a frame on every change.
// Assumes sel_mode is quasi-static configuration in the clk domain.
module sideband_serializer #(
    parameter int NUM_SIG     = 16,
    parameter int LOW_GROUP   = 8,
    parameter int START_BITS  = 2,
    parameter int STOP_BITS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SIG-1:0] sig_in,
    input  logic [1:0]         sel_mode,
    output logic               ser_out,
    output logic               busy
);
    logic [NUM_SIG-1:0] sync_vec;
    logic [NUM_SIG-1:0] masked_vec;
    logic               changed;

    sbs_sync #(.WIDTH(NUM_SIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sig_in),
        .q_o   (sync_vec)
    );

    sbs_select #(.NUM_SIG(NUM_SIG), .LOW_GROUP(LOW_GROUP)) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_vec),
        .mode_i    (sel_mode),
        .masked_o  (masked_vec),
        .changed_o (changed)
    );

    sbs_shift #(.NUM_SIG(NUM_SIG), .START_BITS(START_BITS),
                .STOP_BITS(STOP_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_i    (masked_vec),
        .changed_i (changed),
        .ser_o     (ser_out),
        .busy_o    (busy)
    );
endmodule

// File: rtl/sbs_checker.sv
`timescale 1ns/1ps
// sbs_checker: port-level properties of the serial shifter, bound to the top.
// Tracks bit position and the mode in force at frame load by itself.
module sbs_checker #(
    parameter int NUM_SIG    = 16,
    parameter int LOW_GROUP  = 8,
    parameter int START_BITS = 2,
    parameter int STOP_BITS  = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel_mode,
    input logic       ser_out,
    input logic       busy
);
    localparam int FRAME_LEN = START_BITS + NUM_SIG + STOP_BITS;
    localparam int LW        = $clog2(FRAME_LEN + 1);
    localparam logic [LW-1:0] L_FRAME = LW'(FRAME_LEN);
    localparam logic [LW-1:0] L_START = LW'(START_BITS);
    localparam logic [LW-1:0] L_DATA1 = LW'(START_BITS + 1);
    localparam logic [LW-1:0] L_LOWHI = LW'(START_BITS + LOW_GROUP);
    localparam logic [LW-1:0] L_STOP  = LW'(START_BITS + NUM_SIG);

    logic [LW-1:0] run_len;
    logic [1:0]    ld_mode;

    // Count bit times of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // Mode seen while idle is the one used at the next load.
    always_ff @(posedge clk) begin
        if (!rst_n)     ld_mode <= 2'b00;
        else if (!busy) ld_mode <= sel_mode;
    end

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out);
    assert_start_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len < L_START) |-> !ser_out);
    assert_stop_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len >= L_STOP) |-> ser_out);
    assert_len_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < L_FRAME));
    assert_len_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == L_FRAME));
    assert_mask_suspend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_mode == 2'b00 && run_len >= L_DATA1 && run_len < L_STOP)
        |-> !ser_out);
    assert_mask_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_mode == 2'b01 && run_len >= L_LOWHI && run_len < L_STOP)
        |-> !ser_out);
endmodule

bind sideband_serializer sbs_checker #(
    .NUM_SIG(NUM_SIG), .LOW_GROUP(LOW_GROUP),
    .START_BITS(START_BITS), .STOP_BITS(STOP_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_mode (sel_mode),
    .ser_out  (ser_out),
    .busy     (busy)
);

// File: tb/sideband_serializer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues predicted frames, the monitor
// collects frames from the line and compares them in order.
module sideband_serializer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] sig;
    logic [1:0]  mode;
    logic        ser_out;
    logic        busy;

    int checks = 0;
    int errors = 0;
    logic [19:0] expq [$];

    always #10 clk = ~clk;

    sideband_serializer uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig), .sel_mode(mode),
        .ser_out(ser_out), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] masked(input logic [15:0] s, input logic [1:0] m);
        if (m == 2'b00)      return s & 16'h0001;
        else if (m == 2'b01) return s & 16'h00FF;
        else                 return s;
    endfunction

    function automatic logic [19:0] mk_frame(input logic [15:0] d);
        return {2'b11, d, 2'b00};
    endfunction

    task automatic expect_frame(input logic [15:0] d);
        expq.push_back(mk_frame(d));
    endtask

    task automatic drive(input logic [15:0] s, input logic [1:0] m);
        @(negedge clk);
        sig  = s;
        mode = m;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        repeat (4) @(negedge clk);
        while (quiet < 4) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    task automatic no_frame(input int cycles, input string req);
        int seen = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0, req, "busy cycles without selected change", seen, 0);
    endtask

    // Monitor: collect bit times and compare with the queue.
    logic [19:0] cap;
    logic [19:0] exp_f;
    int          idx = 0;
    bit          gap_watch = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (gap_watch) begin
                gap_watch = 0;
                chk(!busy, "R8", "idle bit after frame", busy, 0);
            end
            if (busy) begin
                cap[idx] = ser_out;
                idx++;
                if (idx == 20) begin
                    idx = 0;
                    gap_watch = 1;
                    if (expq.size() == 0) begin
                        chk(0, "R3", "unexpected frame", cap, 0);
                    end else begin
                        exp_f = expq.pop_front();
                        chk(cap == exp_f, "R1", "frame content", cap, exp_f);
                    end
                end
            end else if (idx != 0) begin
                chk(0, "R9", "frame too short", idx, 20);
                idx = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R3", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sig   = '0;
        mode  = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R2", "busy after reset", busy, 0);
        chk(ser_out == 1'b1, "R2", "line after reset", ser_out, 1);

        // R3 latency and R4 suspend-only frame.
        drive(16'h0001, 2'b00);
        expect_frame(masked(16'h0001, 2'b00));
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(busy == 1'b0, "R3", "busy before third edge", busy, 0);
        @(posedge clk); @(negedge clk);
        chk(busy == 1'b1, "R3", "busy after third edge", busy, 1);
        chk(ser_out == 1'b0, "R3", "first start bit", ser_out, 0);
        wait_idle();
        chk(ser_out == 1'b1, "R2", "line idle between frames", ser_out, 1);

        // R7: unselected inputs change in mode 00.
        drive(16'hFFFF, 2'b00);
        no_frame(30, "R7");

        // R10 and R5: mode change alters masked word.
        drive(16'hFFFF, 2'b01);
        expect_frame(masked(16'hFFFF, 2'b01));
        wait_idle();
        drive(16'hA5C3, 2'b01);
        expect_frame(masked(16'hA5C3, 2'b01));
        wait_idle();
        // R5/R7: only bits 8-15 change.
        drive(16'h5AC3, 2'b01);
        no_frame(30, "R7");

        // R6: all inputs.
        drive(16'h5AC3, 2'b10);
        expect_frame(masked(16'h5AC3, 2'b10));
        wait_idle();
        drive(16'h1234, 2'b10);
        expect_frame(masked(16'h1234, 2'b10));
        wait_idle();
        drive(16'h1234, 2'b11);
        no_frame(30, "R6");
        drive(16'h8001, 2'b11);
        expect_frame(masked(16'h8001, 2'b11));
        wait_idle();

        // R8: two changes during a frame give one frame with latest values.
        drive(16'h0F0F, 2'b10);
        expect_frame(16'h0F0F);
        repeat (8) @(negedge clk);
        chk(busy == 1'b1, "R8", "frame in progress", busy, 1);
        drive(16'h0F10, 2'b10);
        repeat (2) @(negedge clk);
        drive(16'h7777, 2'b10);
        expect_frame(16'h7777);
        wait_idle();

        // R4: back to suspend-only.
        drive(16'h7777, 2'b00);
        expect_frame(masked(16'h7777, 2'b00));
        wait_idle();
        drive(16'h7776, 2'b00);
        expect_frame(masked(16'h7776, 2'b00));
        wait_idle();

        chk(expq.size() == 0, "R3", "predicted frames not sent", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule